// File: doc/BRIEF.md
# Comma-Synchronised Byte Scrambler Pair

This block whitens a byte-wide symbol stream ahead of an 8b/10b encoder and restores it after the decoder. The transmit lane XORs each data byte with eight keystream bits drawn from a 16-bit linear feedback shift register. The receive lane runs an identical register and XORs again, which returns the original payload. Control characters pass through unchanged. A comma control character reloads the register at each end, so the two ends align on the same keystream without any side channel. The whitening keeps idle or constant payload from putting a repeating bit pattern on the line, where an adaptive equalizer would treat it as intersymbol interference.

Both lanes sit in one top module and have independent clocked state. In a system the transmit output feeds the encoder, and the decoder's output feeds the receive input on the far chip. Each lane registers its output once, so a symbol appears one cycle after it is accepted.

Top module: `scr_link`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, each lane drives valid, K flag and data outputs to 0, and its register holds the seed 0xFFFF.
- R2: For each accepted non-comma symbol, the register takes eight steps, starting with bit 0 of the byte. In each step the keystream bit is state bit 15, and the new state is {state[14:0], state[15]^state[4]^state[3]^state[2]}. This is the polynomial x^16+x^5+x^4+x^3+1. The first data byte after a reseed is therefore XORed with 0xFF.
- R3: A symbol presented with valid_i high appears at the lane's outputs one clock later, with valid_o high. A cycle with valid_i low gives valid_o low one clock later.
- R4: A symbol with the K flag set leaves the lane with its byte and K flag unchanged. When it is not a comma, the register still takes its eight steps.
- R5: A comma is K flag 1 with byte 0xBC. It passes unscrambled and reloads the register with 0xFFFF, so the next data byte is XORed with 0xFF.
- R6: While valid_i is low, the register holds its state and data_o and k_o keep their values.
- R7: When tx outputs feed the rx inputs, rx outputs reproduce the original bytes and K flags symbol for symbol, across commas and idle gaps.
- R8: A run of sixteen constant 0x00 data bytes after a comma does not give sixteen equal transmit bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Payload byte to scramble |
| tx_k_i | input | 1 | Payload symbol is a control character |
| tx_valid_i | input | 1 | Payload symbol present |
| tx_data_o | output | 8 | Scrambled byte |
| tx_k_o | output | 1 | Control flag, delayed |
| tx_valid_o | output | 1 | Scrambled symbol present |
| rx_data_i | input | 8 | Line byte to descramble |
| rx_k_i | input | 1 | Line symbol is a control character |
| rx_valid_i | input | 1 | Line symbol present |
| rx_data_o | output | 8 | Recovered byte |
| rx_k_o | output | 1 | Control flag, delayed |
| rx_valid_o | output | 1 | Recovered symbol present |

## Verification
On every cycle, the assertions check the one-cycle valid latency of both lanes, the transparency of control characters, output hold while idle, and the fixed 0xFF keystream byte after a comma. Only the bench scenarios can show the full keystream sequence over long runs. The same holds for recovery of the payload through the two chained lanes, for the effect of idle gaps on the stepping, and for the variation of constant payload.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
  // state bits feeding back: x^16, x^5, x^4, x^3 -> bits 15,4,3,2
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h801C;
  localparam logic [DATA_W-1:0] COMMA_BYTE = 8'hBC;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter int unsigned W = scr_pkg::LFSR_W,
  parameter int unsigned STEPS = scr_pkg::DATA_W,
  parameter logic [W-1:0] TAPS = scr_pkg::LFSR_TAPS,
  parameter logic [W-1:0] SEED = scr_pkg::LFSR_SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  output logic [STEPS-1:0] ks_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;

  always_comb begin
    logic [W-1:0] s;
    s = state_q;
    ks_o = '0;
    for (int i = 0; i < STEPS; i++) begin
      ks_o[i] = s[W-1];
      s = {s[W-2:0], ^(s & TAPS)};
    end
    state_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= state_nxt;
  end
endmodule

// File: rtl/scr_lane.sv
module scr_lane #(
  parameter int unsigned DATA_W = scr_pkg::DATA_W,
  parameter logic [DATA_W-1:0] COMMA = scr_pkg::COMMA_BYTE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              k_i,
  input  logic              valid_i,
  output logic [DATA_W-1:0] data_o,
  output logic              k_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] ks;
  logic              is_comma;

  assign is_comma = valid_i && k_i && (data_i == COMMA);

  scr_lfsr #(.STEPS(DATA_W)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (valid_i && !is_comma),
    .load_i (is_comma),
    .ks_o   (ks)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      k_o     <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        k_o    <= k_i;
        data_o <= k_i ? data_i : (data_i ^ ks);
      end
    end
  end
endmodule

// File: rtl/scr_link.sv
module scr_link #(
  parameter int unsigned DATA_W = scr_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_k_i,
  input  logic              tx_valid_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_k_o,
  output logic              tx_valid_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_k_i,
  input  logic              rx_valid_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_k_o,
  output logic              rx_valid_o
);
  scr_lane #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .data_i(tx_data_i), .k_i(tx_k_i), .valid_i(tx_valid_i),
    .data_o(tx_data_o), .k_o(tx_k_o), .valid_o(tx_valid_o)
  );

  scr_lane #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .data_i(rx_data_i), .k_i(rx_k_i), .valid_i(rx_valid_i),
    .data_o(rx_data_o), .k_o(rx_k_o), .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/scr_link_chk.sv
module scr_link_chk #(
  parameter int unsigned DATA_W = scr_pkg::DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] tx_data_i,
  input logic              tx_k_i,
  input logic              tx_valid_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_k_o,
  input logic              tx_valid_o,
  input logic              rx_valid_i,
  input logic              rx_valid_o
);
  localparam logic [DATA_W-1:0] COMMA = scr_pkg::COMMA_BYTE;

  p_tx_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o == $past(tx_valid_i));

  p_rx_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o == $past(rx_valid_i));

  p_k_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_k_i) |=> (tx_k_o && tx_data_o == $past(tx_data_i)));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> ($stable(tx_data_o) && $stable(tx_k_o)));

  p_reseed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && !tx_k_i && $past(tx_valid_i && tx_k_i && tx_data_i == COMMA))
    |=> (tx_data_o == ~$past(tx_data_i)));
endmodule

bind scr_link scr_link_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_data_i  (tx_data_i),
  .tx_k_i     (tx_k_i),
  .tx_valid_i (tx_valid_i),
  .tx_data_o  (tx_data_o),
  .tx_k_o     (tx_k_o),
  .tx_valid_o (tx_valid_o),
  .rx_valid_i (rx_valid_i),
  .rx_valid_o (rx_valid_o)
);

// File: tb/scr_link_tb_top.sv
`timescale 1ns/1ps
module scr_link_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_d = '0;
  logic       tx_k = 1'b0;
  logic       tx_v = 1'b0;
  logic [7:0] tx_dq, rx_dq;
  logic       tx_kq, tx_vq, rx_kq, rx_vq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] tx_q[$];
  logic [8:0] rx_q[$];
  logic [15:0] m_state = 16'hFFFF;

  bit         cap_on = 1'b0;
  logic [7:0] cap[$];

  always #4 clk = ~clk;

  scr_link dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_data_i(tx_d), .tx_k_i(tx_k), .tx_valid_i(tx_v),
    .tx_data_o(tx_dq), .tx_k_o(tx_kq), .tx_valid_o(tx_vq),
    .rx_data_i(tx_dq), .rx_k_i(tx_kq), .rx_valid_i(tx_vq),
    .rx_data_o(rx_dq), .rx_k_o(rx_kq), .rx_valid_o(rx_vq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // model built from R2/R4/R5: eight steps, bit 0 first, comma reseeds
  task automatic send(input logic k, input logic [7:0] d);
    logic [7:0] ks;
    logic [15:0] s;
    logic [7:0] e;
    s = m_state;
    for (int i = 0; i < 8; i++) begin
      ks[i] = s[15];
      s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
    end
    if (k && d == 8'hBC) begin
      e = d;
      m_state = 16'hFFFF;
    end else begin
      e = k ? d : (d ^ ks);
      m_state = s;
    end
    tx_q.push_back({k, e});
    rx_q.push_back({k, d});
    tx_d = d; tx_k = k; tx_v = 1'b1;
    @(negedge clk);
    tx_v = 1'b0;
  endtask

  task automatic idle(input int n);
    tx_v = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: tx output against model (R2, R4, R5), rx against payload (R7)
  always @(negedge clk) begin
    if (rst_n && tx_vq) begin
      if (tx_q.size() == 0) check("R3 unexpected tx", 1, 0);
      else begin
        logic [8:0] e;
        e = tx_q.pop_front();
        check("R2 tx symbol", {tx_kq, tx_dq}, e);
        if (cap_on) cap.push_back(tx_dq);
      end
    end
    if (rst_n && rx_vq) begin
      if (rx_q.size() == 0) check("R7 unexpected rx", 1, 0);
      else begin
        logic [8:0] e;
        e = rx_q.pop_front();
        check("R7 round trip", {rx_kq, rx_dq}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset tx", {tx_vq, tx_kq, tx_dq}, 0);
    check("R1 reset rx", {rx_vq, rx_kq, rx_dq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {tx_vq, rx_vq, tx_dq}, 0);

    // R2: first byte after reset uses keystream 0xFF
    tx_d = 8'h5A; tx_k = 1'b0; tx_v = 1'b1;
    tx_q.push_back({1'b0, 8'hA5}); rx_q.push_back({1'b0, 8'h5A});
    begin
      logic [15:0] s;
      s = m_state;
      for (int i = 0; i < 8; i++) s = {s[14:0], s[15] ^ s[4] ^ s[3] ^ s[2]};
      m_state = s;
    end
    @(negedge clk); tx_v = 1'b0;
    check("R3 valid after one cycle", tx_vq, 1);
    check("R2 first byte xor ff", tx_dq, 8'hA5);

    // R6: idle gap holds data and state
    held = tx_dq;
    @(negedge clk);
    check("R3 valid low after idle", tx_vq, 0);
    idle(4);
    check("R6 data held", tx_dq, held);
    for (int i = 0; i < 20; i++) send(1'b0, 8'(i * 37 + 3));

    // R4: non-comma K character passes, LFSR advances
    send(1'b1, 8'h1C);
    check("R4 k char unchanged", {tx_kq, tx_dq}, {1'b1, 8'h1C});
    send(1'b0, 8'h00);
    send(1'b0, 8'hFF);

    // R5: comma mid-stream then data
    send(1'b1, 8'hBC);
    send(1'b0, 8'h33);
    check("R5 after comma xor ff", tx_dq, 8'hCC);

    // R8: constant payload after comma
    send(1'b1, 8'hBC);
    cap_on = 1'b1;
    for (int i = 0; i < 16; i++) send(1'b0, 8'h00);
    @(negedge clk);
    cap_on = 1'b0;
    begin
      int diff;
      diff = 0;
      foreach (cap[i]) if (cap[i] != cap[0]) diff++;
      check("R8 constant input varies", (diff > 0) ? 1 : 0, 1);
    end

    // R7: mixed stream with gaps and commas
    for (int i = 0; i < 60; i++) begin
      if (i % 17 == 5) send(1'b1, 8'hBC);
      else if (i % 11 == 3) send(1'b1, 8'hF7);
      else send(1'b0, 8'(i * 91 + 7));
      if (i % 7 == 0) idle(2);
    end
    idle(4);
    check("R7 tx queue drained", tx_q.size(), 0);
    check("R7 rx queue drained", rx_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule